// File: doc/BRIEF.md
# Canonical Huffman Table Generator

This block turns a compact description of a Huffman code into the table that a lookup-based encoder reads. Before compression starts, a stream of run-length bytes is fed in. Each byte gives one code length and how many consecutive symbols share it. The block expands these runs into one length per symbol. It then derives every code word by the canonical rules. Only lengths cross the configuration path, and no tree is ever built.

Once every symbol has a length, the generator walks the lengths from shortest to longest. Within one length it takes symbols in index order. Each symbol with a non-zero length is written once to a table write port, addressed by the symbol value, together with its valid-bit count. When the walk ends, a done flag rises and stays high. The table then stays fixed for as long as compression runs.

Top module: `canon_table_gen`

## Requirements
- R1: Each configuration byte carries a code length in bits [7:4] and a repeat count minus one in bits [3:0]. The runs fill symbol lengths in order, starting at symbol 0.
- R2: Once all NUM_SYM lengths are filled, further bytes have no effect. A run that would pass the last symbol is cut short at the last symbol.
- R3: A symbol whose length is 0 is never written to the table.
- R4: Symbols that share a code length receive consecutive code values, rising with the symbol index.
- R5: The first symbol of the shortest length present receives code 0.
- R6: The first code of a length equals (last code of the previous length present + 1) shifted left by the difference of the two lengths.
- R7: Each symbol with a non-zero length is written exactly once. The write uses address = symbol, bit count = its length, and the code right-aligned so that no bit at or above the bit count is set.
- R8: Writes come out in strictly increasing order of (length, symbol).
- R9: Out of reset, done is low and no write is issued. Done rises after the last write and then stays high, and no write follows it.
- R10: For any set of lengths that meets the Kraft inequality, no written code is a prefix of another written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Configuration byte present this cycle |
| cfg_byte | input | 8 | Run-length byte: length in [7:4], repeat minus one in [3:0] |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | 6 | Table address (symbol value) |
| tbl_code | output | 15 | Code word, right-aligned |
| tbl_bits | output | 4 | Valid bits in the code word |
| done | output | 1 | Table complete |

## Verification
Several properties are checked on every cycle: the (length, symbol) order of the writes, that the first write carries code 0, that each code fits within its bit count, the bit-count range, and that done is sticky and never coincides with a write. Only the bench's scenarios can show the rest. This covers the correct expansion of runs, truncation and the ignoring of excess bytes, the exact code values against an independent canonical build, the absence of writes for unused symbols, and the prefix-free property of the whole table. The scenarios include a uniform length, gaps between lengths up to the longest length, runs listed longest-first, and a run that crosses the symbol limit.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [1:0] {
    GEN_WAIT = 2'd0,
    GEN_SCAN = 2'd1,
    GEN_DONE = 2'd2
  } gen_state_e;

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/chg_run_expander.sv
module chg_run_expander #(
  parameter int NUM_SYM = 64,
  parameter int LEN_W   = 4,
  parameter int RUN_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [LEN_W+RUN_W-1:0]          in_byte,
  output logic [NUM_SYM-1:0][LEN_W-1:0]   lens_o,
  output logic                            full_o
);

  localparam int SYM_W = $clog2(NUM_SYM);
  localparam int PTR_W = SYM_W + 1;
  localparam int SUM_W = PTR_W + RUN_W;

  logic [PTR_W-1:0]               fill_q, fill_d;
  logic [NUM_SYM-1:0][LEN_W-1:0]  lens_q, lens_d;
  logic [NUM_SYM-1:0]             slot_hit;
  logic [LEN_W-1:0]               run_len;
  logic [RUN_W-1:0]               run_m1;
  logic [SUM_W-1:0]               run_end;
  logic                           full, take;

  assign run_len = in_byte[LEN_W+RUN_W-1:RUN_W];
  assign run_m1  = in_byte[RUN_W-1:0];
  assign run_end = SUM_W'(fill_q) + SUM_W'(run_m1) + SUM_W'(1);
  assign full    = (fill_q == PTR_W'(NUM_SYM));
  assign take    = in_valid && !full;

  // one comparator pair per symbol slot: is this slot covered by the run
  for (genvar g = 0; g < NUM_SYM; g++) begin : g_slot
    assign slot_hit[g] = (SUM_W'(g) >= SUM_W'(fill_q)) && (SUM_W'(g) < run_end);
  end

  always_comb begin
    lens_d = lens_q;
    for (int i = 0; i < NUM_SYM; i++) begin
      if (slot_hit[i]) lens_d[i] = run_len;
    end
    if (run_end > SUM_W'(NUM_SYM)) fill_d = PTR_W'(NUM_SYM);
    else                           fill_d = PTR_W'(run_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      lens_q <= '0;
    end else if (take) begin
      fill_q <= fill_d;
      lens_q <= lens_d;
    end
  end

  assign lens_o = lens_q;
  assign full_o = full;

endmodule

// File: rtl/chg_code_assign.sv
module chg_code_assign
  import chg_pkg::*;
#(
  parameter int NUM_SYM = 64,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            go,
  input  logic [NUM_SYM-1:0][LEN_W-1:0]   lens_i,
  output logic                            tbl_we,
  output logic [$clog2(NUM_SYM)-1:0]      tbl_addr,
  output logic [MAX_LEN-1:0]              tbl_code,
  output logic [LEN_W-1:0]                tbl_bits,
  output logic                            done
);

  localparam int SYM_W  = $clog2(NUM_SYM);
  localparam int CODE_W = MAX_LEN + 1;

  gen_state_e          state_q, state_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [SYM_W-1:0]    sym_q, sym_d;
  logic [CODE_W-1:0]   code_q, code_d, code_inc;
  logic                hit, last_sym, last_len, adv;

  assign hit      = (state_q == GEN_SCAN) && (lens_i[sym_q] == len_q);
  assign last_sym = (sym_q == SYM_W'(NUM_SYM - 1));
  assign last_len = (len_q == LEN_W'(MAX_LEN));
  assign code_inc = hit ? code_q + CODE_W'(1) : code_q;
  assign adv      = ((state_q == GEN_WAIT) && go) || (state_q == GEN_SCAN);

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    sym_d   = sym_q;
    code_d  = code_q;
    unique case (state_q)
      GEN_WAIT: begin
        state_d = GEN_SCAN;
        len_d   = LEN_W'(1);
        sym_d   = '0;
        code_d  = '0;
      end
      GEN_SCAN: begin
        if (last_sym) begin
          sym_d = '0;
          if (last_len) begin
            state_d = GEN_DONE;
            code_d  = code_inc;
          end else begin
            len_d  = len_q + LEN_W'(1);
            code_d = code_inc << 1;
          end
        end else begin
          sym_d  = sym_q + SYM_W'(1);
          code_d = code_inc;
        end
      end
      default: state_d = GEN_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_WAIT;
      len_q   <= '0;
      sym_q   <= '0;
      code_q  <= '0;
    end else if (adv) begin
      state_q <= state_d;
      len_q   <= len_d;
      sym_q   <= sym_d;
      code_q  <= code_d;
    end
  end

  assign tbl_we   = hit;
  assign tbl_addr = sym_q;
  assign tbl_code = code_q[MAX_LEN-1:0];
  assign tbl_bits = len_q;
  assign done     = (state_q == GEN_DONE);

endmodule

// File: rtl/canon_table_gen.sv
module canon_table_gen #(
  parameter int NUM_SYM = 64,
  parameter int MAX_LEN = 15,
  parameter int LEN_W   = 4,
  parameter int RUN_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_valid,
  input  logic [LEN_W+RUN_W-1:0]      cfg_byte,
  output logic                        tbl_we,
  output logic [$clog2(NUM_SYM)-1:0]  tbl_addr,
  output logic [MAX_LEN-1:0]          tbl_code,
  output logic [LEN_W-1:0]            tbl_bits,
  output logic                        done
);

  logic                           rst_n_s;
  logic [NUM_SYM-1:0][LEN_W-1:0]  lens;
  logic                           lens_full;

  chg_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  chg_run_expander #(
    .NUM_SYM (NUM_SYM),
    .LEN_W   (LEN_W),
    .RUN_W   (RUN_W)
  ) u_expand (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (cfg_valid),
    .in_byte  (cfg_byte),
    .lens_o   (lens),
    .full_o   (lens_full)
  );

  chg_code_assign #(
    .NUM_SYM (NUM_SYM),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
  ) u_assign (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (lens_full),
    .lens_i   (lens),
    .tbl_we   (tbl_we),
    .tbl_addr (tbl_addr),
    .tbl_code (tbl_code),
    .tbl_bits (tbl_bits),
    .done     (done)
  );

endmodule

// File: rtl/canon_table_gen_chk.sv
module canon_table_gen_chk #(
  parameter int NUM_SYM = 64,
  parameter int MAX_LEN = 15,
  parameter int LEN_W   = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tbl_we,
  input logic [$clog2(NUM_SYM)-1:0]  tbl_addr,
  input logic [MAX_LEN-1:0]          tbl_code,
  input logic [LEN_W-1:0]            tbl_bits,
  input logic                        done
);

  localparam int KEY_W = LEN_W + $clog2(NUM_SYM);

  logic [KEY_W-1:0] last_key_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_key_q <= '0;
      seen_q     <= 1'b0;
    end else if (tbl_we) begin
      last_key_q <= {tbl_bits, tbl_addr};
      seen_q     <= 1'b1;
    end
  end

  // R8
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && seen_q) |-> ({tbl_bits, tbl_addr} > last_key_q));

  // R5
  first_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !seen_q) |-> (tbl_code == '0));

  // R7
  code_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ((32'(tbl_code) >> tbl_bits) == 32'd0));

  // R3
  bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ((tbl_bits != '0) && (32'(tbl_bits) <= MAX_LEN)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tbl_we);

endmodule

bind canon_table_gen canon_table_gen_chk #(
  .NUM_SYM (NUM_SYM),
  .MAX_LEN (MAX_LEN),
  .LEN_W   (LEN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tbl_we   (tbl_we),
  .tbl_addr (tbl_addr),
  .tbl_code (tbl_code),
  .tbl_bits (tbl_bits),
  .done     (done)
);

// File: tb/canon_table_gen_test.sv
`timescale 1ns/1ps
module canon_table_gen_test;

  localparam int N  = 64;
  localparam int ML = 15;

  logic       clk;
  logic       rst_n;
  logic       cfg_valid;
  logic [7:0] cfg_byte;
  logic       tbl_we;
  logic [5:0] tbl_addr;
  logic [14:0] tbl_code;
  logic [3:0] tbl_bits;
  logic       done;

  int checks;
  int fails;
  int exp_len  [N];
  int got_code [N];
  int got_bits [N];
  int wr_cnt   [N];
  int wr_total;
  int last_key;
  int order_err;
  int wr_after_done;

  canon_table_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_byte  (cfg_byte),
    .tbl_we    (tbl_we),
    .tbl_addr  (tbl_addr),
    .tbl_code  (tbl_code),
    .tbl_bits  (tbl_bits),
    .done      (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // write-port monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n && tbl_we) begin
      int a;
      int key;
      a   = int'(tbl_addr);
      key = int'(tbl_bits) * 256 + a;
      if (key <= last_key) order_err++;
      if (done) wr_after_done++;
      last_key    = key;
      got_code[a] = int'(tbl_code);
      got_bits[a] = int'(tbl_bits);
      wr_cnt[a]++;
      wr_total++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [7:0] bytes[], input int gap);
    int pos;
    int used;
    int t;
    int snap;
    int code;
    int bl_count  [ML+1];
    int next_code [ML+1];
    int ec;
    bit pf_ok;

    rst_n     = 1'b0;
    cfg_valid = 1'b0;
    cfg_byte  = 8'h00;
    for (int s = 0; s < N; s++) begin
      exp_len[s] = 0; got_code[s] = -1; got_bits[s] = -1; wr_cnt[s] = 0;
    end
    wr_total = 0; last_key = -1; order_err = 0; wr_after_done = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done == 1'b0, "R9", "done in reset", int'(done), 0);
    check(tbl_we == 1'b0, "R9", "write in reset", int'(tbl_we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: expected expansion, clipped at N symbols
    pos = 0;
    foreach (bytes[b]) begin
      for (int k = 0; k <= int'(bytes[b][3:0]); k++) begin
        if (pos < N) begin
          exp_len[pos] = int'(bytes[b][7:4]);
          pos++;
        end
      end
    end

    foreach (bytes[b]) begin
      cfg_valid = 1'b1;
      cfg_byte  = bytes[b];
      @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        cfg_valid = 1'b0;
        cfg_byte  = 8'hFF;
        @(negedge clk);
      end
    end
    cfg_valid = 1'b0;
    cfg_byte  = 8'h00;

    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R9", "done reached (watchdog)", int'(done), 1);

    snap = wr_total;
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R9", "done held", int'(done), 1);
    check(wr_total == snap && wr_after_done == 0, "R9", "writes after done",
          wr_total - snap + wr_after_done, 0);
    check(order_err == 0, "R8", "out-of-order writes", order_err, 0);

    // independent canonical build from per-length counts
    for (int l = 0; l <= ML; l++) bl_count[l] = 0;
    used = 0;
    for (int s = 0; s < N; s++) begin
      if (exp_len[s] != 0) begin
        bl_count[exp_len[s]]++;
        used++;
      end
    end
    check(wr_total == used, "R2", "total writes", wr_total, used);
    code = 0;
    next_code[0] = 0;
    for (int l = 1; l <= ML; l++) begin
      code = (code + bl_count[l-1]) << 1;
      next_code[l] = code;
    end

    for (int s = 0; s < N; s++) begin
      if (exp_len[s] == 0) begin
        check(wr_cnt[s] == 0, "R3", $sformatf("sym %0d unused written", s), wr_cnt[s], 0);
      end else begin
        ec = next_code[exp_len[s]];
        next_code[exp_len[s]]++;
        check(wr_cnt[s] == 1, "R7", $sformatf("sym %0d write count", s), wr_cnt[s], 1);
        check(got_bits[s] == exp_len[s], "R1", $sformatf("sym %0d bits", s),
              got_bits[s], exp_len[s]);
        check(got_code[s] == ec, "R4 R5 R6", $sformatf("sym %0d code", s),
              got_code[s], ec);
      end
    end

    // R10: no code is a prefix of another
    pf_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j && got_bits[i] > 0 && got_bits[j] >= got_bits[i]) begin
          if ((got_code[j] >> (got_bits[j] - got_bits[i])) == got_code[i]) pf_ok = 1'b0;
        end
      end
    end
    check(pf_ok, "R10", "prefix-free table", int'(pf_ok), 1);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    // uniform length 6: codes 0..63
    run_cfg('{8'h6F, 8'h6F, 8'h6F, 8'h6F}, 0);
    // gaps between lengths, unused symbols, longest length reached
    run_cfg('{8'h10, 8'h02, 8'h31, 8'h53, 8'h8F, 8'h9F, 8'hFF, 8'hF5}, 2);
    // long runs first in symbol order, trailing bytes ignored
    run_cfg('{8'h8F, 8'h20, 8'h33, 8'h41, 8'h0F, 8'h0F, 8'h08, 8'h1F, 8'h1F}, 1);
    // last run crosses the symbol limit and is cut short
    run_cfg('{8'h7F, 8'h7F, 8'h7F, 8'h7A, 8'h8F, 8'h30}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL R9 global watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule